// File: doc/BRIEF.md
# Program ROM Bank Mapper with Reversed-Bit Layout

This block turns a CPU address in the upper part of the address space into an 8 KB program ROM page number. Software programs four 7-bit bank registers and one control register through a small write port. The control register picks one of four window layouts for 0x8000–0xFFFF: one 32 KB window, two 16 KB windows, or four 8 KB windows. The fourth layout uses the same four windows but reverses the bit order of every bank register before it is used. A control bit also chooses whether the top window follows bank register 3 or is pinned to the final page of the ROM. A further enable maps a ROM page into 0x6000–0x7FFF, and the page chosen for that window depends on the layout.

The address and the register contents are combined in logic, and the result is captured in an output register. The page number and the low-window hit therefore appear one clock after the address is presented. The page number is cut to the number of page bits that the attached ROM decodes.

Top module: `prg_bank_mapper`

## Requirements
- R1: After reset all bank registers, the layout field and the low-window enable are zero, and both outputs are zero. The top window then holds the final ROM page, so address 0xE000 gives page 0xFF with the default 8 page bits.
- R2: A write with `wr_sel` 0 to 3 loads bank register `wr_sel` with `wr_data[6:0]`. Data bit 7 is dropped.
- R3: A write with `wr_sel` 4 loads the layout field from `wr_data[2:0]` and the low-window enable from `wr_data[7]`. Data bits 6:3 have no effect.
- R4: When layout bits [1:0] equal 3, every bank register is used with its bits reversed: bit0→6, bit1→5, bit2→4, bit4→2, bit5→1, bit6→0. Bit 3 becomes 0.
- R5: The top bank is bank register 3 when layout bit 2 is set, and all ones (the final page) when it is clear.
- R6: When layout bits [1:0] equal 0, address 0x8000+ maps to page top×4 + A14:A13.
- R7: When layout bits [1:0] equal 1, addresses with A14 low map to page reg1×2 + A13, and addresses with A14 high map to page top×2 + A13.
- R8: When layout bits [1:0] equal 2 or 3, A14:A13 selects reg0, reg1, reg2 or the top bank as the page.
- R9: When the low window is enabled, 0x6000–0x7FFF maps to page reg3×4+3 in layout 0, reg3×2+1 in layout 1, and reg3 in layouts 2 and 3. Reg3 is reversed in layout 3.
- R10: `low_hit_o` is 1 only for an address in 0x6000–0x7FFF while the low window is enabled. `page_o` is 0 for any address below 0x8000 that does not hit.
- R11: `page_o` holds the low `PAGE_W` bits of the computed page and is registered, so it reflects the address and registers one clock after they are applied.
- R12: Writes with `wr_sel` 5 to 7 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select: 0–3 bank, 4 control |
| wr_data | input | 8 | Write data |
| cpu_addr | input | 16 | CPU address to translate |
| page_o | output | PAGE_W (8) | Registered 8 KB page index |
| low_hit_o | output | 1 | Registered hit for the 0x6000–0x7FFF window |

## Verification
Directed cases set each layout with distinct register values, so that each window shows which register and which address bits it took. They cover the pinned and the programmable top bank, single-bit registers that show the reversal and the dropped middle bit, and writes with bit 7 or unused control bits set. Random writes and addresses cover every layout, top-bank choice and enable state. Addresses below 0x6000, in the low window with the enable on and off, and at the upper boundaries separate the hit logic from the page logic.

// File: rtl/prg_map_pkg.sv
package prg_map_pkg;
  typedef enum logic [1:0] {
    LAYOUT_32K     = 2'd0,
    LAYOUT_16K     = 2'd1,
    LAYOUT_8K      = 2'd2,
    LAYOUT_8K_REV  = 2'd3
  } prg_layout_e;

  localparam int unsigned CTRL_SEL   = 4;
  localparam int unsigned CTRL_EN_B  = 7;
  localparam int unsigned LAYOUT_W   = 3;
endpackage

// File: rtl/prg_bank_regs.sv
module prg_bank_regs
  import prg_map_pkg::*;
#(
  parameter int unsigned BANK_W    = 7,
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned SEL_W     = 3,
  parameter int unsigned DATA_W    = 8
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                wr_en,
  input  logic [SEL_W-1:0]                    wr_sel,
  input  logic [DATA_W-1:0]                   wr_data,
  output logic [NUM_BANKS-1:0][BANK_W-1:0]    bank_o,
  output logic [LAYOUT_W-1:0]                 layout_o,
  output logic                                low_en_o
);

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic hit_sel;
    assign hit_sel = wr_en && (wr_sel == SEL_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        bank_o[g] <= '0;
      end else if (hit_sel) begin
        bank_o[g] <= wr_data[BANK_W-1:0];
      end
    end

    // R2
    bank_load_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_sel == SEL_W'(g)) |=> (bank_o[g] == $past(wr_data[BANK_W-1:0])));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      layout_o <= '0;
      low_en_o <= 1'b0;
    end else if (wr_en && wr_sel == SEL_W'(CTRL_SEL)) begin
      layout_o <= wr_data[LAYOUT_W-1:0];
      low_en_o <= wr_data[CTRL_EN_B];
    end
  end

  // R12
  no_write_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_en || wr_sel > SEL_W'(CTRL_SEL)) |=>
      ($stable(bank_o) && $stable(layout_o) && $stable(low_en_o)));

endmodule

// File: rtl/prg_bit_scramble.sv
module prg_bit_scramble #(
  parameter int unsigned W = 7
) (
  input  logic         en_i,
  input  logic [W-1:0] in_i,
  output logic [W-1:0] out_i
);
  localparam int unsigned MID     = W / 2;
  localparam bit          HAS_MID = (W % 2) == 1;

  for (genvar g = 0; g < W; g++) begin : g_bit
    if (HAS_MID && g == MID) begin : g_mid
      assign out_i[g] = en_i ? 1'b0 : in_i[g];
    end else begin : g_swap
      assign out_i[g] = en_i ? in_i[W-1-g] : in_i[g];
    end
  end

  // R4
  always_comb begin
    if (en_i) begin
      scramble_ones_chk: assert ($countones(out_i) + ((HAS_MID && in_i[MID]) ? 1 : 0)
                                 == $countones(in_i))
        else $error("reversed bank lost or gained bits");
    end
  end

endmodule

// File: rtl/prg_page_calc.sv
module prg_page_calc
  import prg_map_pkg::*;
#(
  parameter int unsigned BANK_W = 7,
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned FULL_W = BANK_W + 2
) (
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [3:0][BANK_W-1:0] bank_i,
  input  logic [LAYOUT_W-1:0]   layout_i,
  input  logic                  low_en_i,
  output logic [FULL_W-1:0]     page_o,
  output logic                  low_hit_o
);
  localparam int unsigned A15 = ADDR_W - 1;
  localparam int unsigned A14 = ADDR_W - 2;
  localparam int unsigned A13 = ADDR_W - 3;

  prg_layout_e          layout;
  logic [BANK_W-1:0]    top_bank;
  logic                 in_rom;
  logic                 in_low;
  logic [FULL_W-1:0]    rom_page;
  logic [FULL_W-1:0]    low_page;

  assign layout   = prg_layout_e'(layout_i[1:0]);
  assign top_bank = layout_i[2] ? bank_i[3] : '1;
  assign in_rom   = addr_i[A15];
  assign in_low   = !addr_i[A15] && addr_i[A14] && addr_i[A13];

  always_comb begin
    unique case (layout)
      LAYOUT_32K: rom_page = {top_bank, addr_i[A14], addr_i[A13]};
      LAYOUT_16K: rom_page = addr_i[A14] ? {1'b0, top_bank, addr_i[A13]}
                                         : {1'b0, bank_i[1], addr_i[A13]};
      default: begin
        unique case ({addr_i[A14], addr_i[A13]})
          2'd0:    rom_page = {2'b00, bank_i[0]};
          2'd1:    rom_page = {2'b00, bank_i[1]};
          2'd2:    rom_page = {2'b00, bank_i[2]};
          default: rom_page = {2'b00, top_bank};
        endcase
      end
    endcase
  end

  always_comb begin
    unique case (layout)
      LAYOUT_32K: low_page = {bank_i[3], 2'b11};
      LAYOUT_16K: low_page = {1'b0, bank_i[3], 1'b1};
      default:    low_page = {2'b00, bank_i[3]};
    endcase
  end

  assign low_hit_o = in_low && low_en_i;

  always_comb begin
    if (in_rom)         page_o = rom_page;
    else if (low_hit_o) page_o = low_page;
    else                page_o = '0;
  end

endmodule

// File: rtl/prg_bank_mapper.sv
module prg_bank_mapper
  import prg_map_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned BANK_W = 7,
  parameter int unsigned SEL_W  = 3,
  parameter int unsigned PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic [PAGE_W-1:0] page_o,
  output logic              low_hit_o
);
  localparam int unsigned NUM_BANKS = 4;
  localparam int unsigned FULL_W    = BANK_W + 2;

  logic [NUM_BANKS-1:0][BANK_W-1:0] bank_raw;
  logic [NUM_BANKS-1:0][BANK_W-1:0] bank_eff;
  logic [LAYOUT_W-1:0]              layout;
  logic                             low_en;
  logic                             reverse_on;
  logic [FULL_W-1:0]                page_full;
  logic                             low_hit;

  prg_bank_regs #(
    .BANK_W(BANK_W), .NUM_BANKS(NUM_BANKS), .SEL_W(SEL_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .bank_o(bank_raw), .layout_o(layout), .low_en_o(low_en)
  );

  assign reverse_on = (layout[1:0] == 2'(LAYOUT_8K_REV));

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_rev
    prg_bit_scramble #(.W(BANK_W)) u_rev (
      .en_i(reverse_on), .in_i(bank_raw[g]), .out_i(bank_eff[g])
    );
  end

  prg_page_calc #(
    .BANK_W(BANK_W), .ADDR_W(ADDR_W), .FULL_W(FULL_W)
  ) u_calc (
    .addr_i(cpu_addr), .bank_i(bank_eff), .layout_i(layout), .low_en_i(low_en),
    .page_o(page_full), .low_hit_o(low_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      page_o    <= '0;
      low_hit_o <= 1'b0;
    end else begin
      page_o    <= page_full[PAGE_W-1:0];
      low_hit_o <= low_hit;
    end
  end

  // R10
  low_hit_window_chk: assert property (@(posedge clk) disable iff (rst)
    low_hit_o |-> ($past(cpu_addr[ADDR_W-1:ADDR_W-3]) == 3'b011));

  // R10
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (!cpu_addr[ADDR_W-1] && cpu_addr[ADDR_W-2:ADDR_W-3] != 2'b11) |=>
      (page_o == '0 && !low_hit_o));

  // R9
  low_disabled_chk: assert property (@(posedge clk) disable iff (rst)
    (!low_en && !wr_en) |=> !low_hit_o);

endmodule

// File: tb/test_prg_bank_mapper.sv
module test_prg_bank_mapper;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [2:0]  wr_sel;
  logic [7:0]  wr_data;
  logic [15:0] cpu_addr;
  logic [7:0]  page_o;
  logic        low_hit_o;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic [6:0] m_bank [4];
  logic [2:0] m_mode;
  logic       m_en;

  always #5 clk = ~clk;

  prg_bank_mapper i_prg_bank_mapper (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .cpu_addr(cpu_addr), .page_o(page_o), .low_hit_o(low_hit_o)
  );

  function automatic logic [6:0] rev7(input logic [6:0] v, input logic on);
    return on ? {v[0], v[1], v[2], 1'b0, v[4], v[5], v[6]} : v;
  endfunction

  function automatic logic exp_hit(input logic [15:0] a);
    return m_en && a[15:13] == 3'b011;
  endfunction

  function automatic logic [7:0] exp_page(input logic [15:0] a);
    logic [6:0] b [4];
    logic [6:0] top;
    int p;
    for (int i = 0; i < 4; i++) b[i] = rev7(m_bank[i], m_mode[1:0] == 2'd3);
    top = m_mode[2] ? b[3] : 7'h7F;
    if (a[15]) begin
      case (m_mode[1:0])
        2'd0: p = top * 4 + a[14:13];
        2'd1: p = (a[14] ? top : b[1]) * 2 + a[13];
        default: case (a[14:13])
          2'd0: p = b[0];
          2'd1: p = b[1];
          2'd2: p = b[2];
          default: p = top;
        endcase
      endcase
    end else if (exp_hit(a)) begin
      case (m_mode[1:0])
        2'd0: p = b[3] * 4 + 3;
        2'd1: p = b[3] * 2 + 1;
        default: p = b[3];
      endcase
    end else p = 0;
    return 8'(p);
  endfunction

  task automatic chk(input string tag, input int got, input int exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (sel < 3'd4) m_bank[sel[1:0]] = d[6:0];
    else if (sel == 3'd4) begin m_mode = d[2:0]; m_en = d[7]; end
  endtask

  task automatic look(input string tag, input logic [15:0] a);
    @(negedge clk);
    cpu_addr = a;
    @(negedge clk);
    chk(tag, page_o, exp_page(a));
    chk(tag, low_hit_o, exp_hit(a));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1; wr_en = 1'b0; wr_sel = '0; wr_data = '0; cpu_addr = 16'h0000;
    for (int i = 0; i < 4; i++) m_bank[i] = '0;
    m_mode = '0; m_en = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state of outputs
    chk("R1 page", page_o, 0);
    chk("R1 hit", low_hit_o, 0);
    rst = 1'b0;
    look("R1 default top page", 16'hE000);
    chk("R1 final page value", page_o, 8'hFF);
    // R6 layout 0 with fixed top
    look("R6 32K a", 16'h8000);
    look("R6 32K b", 16'hC123);
    // R2 data bit 7 dropped, R3 control bits 6:3 ignored
    wr(3'd0, 8'hFF);
    wr(3'd4, 8'h7A);
    look("R2 bank bit7 dropped", 16'h8000);
    chk("R2 value", page_o, 8'h7F);
    look("R3 ignored bits", 16'h6000);
    chk("R3 no enable", low_hit_o, 0);
    // R8 layout 2
    wr(3'd1, 8'h11); wr(3'd2, 8'h22); wr(3'd3, 8'h33);
    look("R8 slot0", 16'h8000); look("R8 slot1", 16'hA000);
    look("R8 slot2", 16'hC000); look("R8 slot3 fixed", 16'hFFFF);
    // R5 programmable top
    wr(3'd4, 8'h06);
    look("R5 top from reg3", 16'hE000);
    chk("R5 value", page_o, 8'h33);
    // R12 unused selects
    wr(3'd5, 8'h55); wr(3'd6, 8'hAA); wr(3'd7, 8'h01);
    look("R12 unchanged", 16'hE000);
    chk("R12 value", page_o, 8'h33);
    // R4 reversal
    wr(3'd4, 8'h83); wr(3'd1, 8'h01);
    look("R4 bit0 to bit6", 16'hA000);
    chk("R4 value", page_o, 8'h40);
    wr(3'd1, 8'h08);
    look("R4 bit3 dropped", 16'hA000);
    chk("R4 drop value", page_o, 8'h00);
    wr(3'd3, 8'h06);
    look("R9 layout3 low", 16'h7FFF);
    chk("R9 rev low", page_o, 8'h30);
    // R7 layout 1
    wr(3'd4, 8'h85); wr(3'd1, 8'h12);
    look("R7 first half", 16'h9FFF); look("R7 second half", 16'hE000);
    look("R9 layout1 low", 16'h6000);
    wr(3'd4, 8'h80);
    look("R9 layout0 low", 16'h6ABC);
    chk("R9 layout0 value", page_o, 8'h1B);
    // R10 boundaries
    look("R10 below window", 16'h5FFF);
    look("R10 top of window", 16'h7FFF);
    wr(3'd4, 8'h00);
    look("R10 disabled", 16'h6000);
    // R11 masking and one-cycle latency
    wr(3'd4, 8'h04); wr(3'd3, 8'h7F);
    look("R11 masked", 16'hE000);
    chk("R11 mask value", page_o, 8'hFF);
    for (int i = 0; i < 600; i++) begin
      if (($urandom % 10) < 3) wr(3'($urandom), 8'($urandom));
      else look("R11 random", 16'($urandom));
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule